// File: doc/BRIEF.md
# Two-Digit Decimal Up-Counter

This block counts from 00 to 99 in decimal and wraps back to 00. It is made of two 4-bit counter stages, each of which has a parallel-load path. The lower stage holds the units digit and the upper stage holds the tens digit. Each stage counts in plain binary over the range 0 to 9. It returns to zero by loading all-zero data on a clock edge. No stage uses an asynchronous clear for this.

A global enable lets the count advance. The tens stage advances only in a cycle where the units stage shows 9. At that same edge the units stage reloads zero. A synchronous clear input zeroes both digits. A combinational carry output marks the last state of the range, so further decades can be chained after this one.

Top module: `bcd_duo_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, both digits become 0 at that edge.
- R2: With clear low and enable high, a units digit below 9 increases by exactly one at the next rising edge.
- R3: With clear low and enable high, a units digit of 9 becomes 0 at the next rising edge.
- R4: The tens digit changes at an edge without clear only if the units digit was 9 and enable was high in the cycle before that edge. When it does change, it rises by one at the same edge where the units digit returns to 0.
- R5: With clear low and enable high, the count 99 becomes 00 at the next rising edge.
- R6: With clear high, both digits are 0 after the next rising edge, whatever the value of enable.
- R7: With clear low and enable low, both digits keep their values across a rising edge.
- R8: carry_out is high exactly when enable is high and the count is 99. The value of clear does not affect it.
- R9: Neither digit output ever holds a value above 9. Digits are unsigned 4-bit BCD, with the units digit on units_o and the tens digit on tens_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous load of zeros into both digits, takes priority over enable |
| enable | input | 1 | Lets the count advance by one per edge |
| units_o | output | 4 | Units digit, BCD |
| tens_o | output | 4 | Tens digit, BCD |
| carry_out | output | 1 | High while enable is high and the count is 99 |

## Verification
The hardest case to reach is the double rollover from 99 to 00. It needs a hundred enabled edges in a row, and both load paths and the tens enable must fire in the same cycle. The stimulus runs more than a hundred enabled cycles from reset, so it passes through 99 at least once. It then counts up to 99 again and parks there with enable low, so that carry_out is seen both with and without enable. A behavioural integer model, taken modulo 100, is compared against the digits on every clock. The stimulus also includes enable patterns with gaps, a clear asserted together with enable, and a reset in the middle of a count.

// File: rtl/bcdc_pkg.sv
// Package: shared widths and limits for the decimal counter.
// Assumes each digit is one BCD nibble.
package bcdc_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_TOP = 9;
    localparam int NUM_DIG   = 2;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcdc_stage_ctrl.sv
// Stage control: decides whether one digit stage loads, and passes the
// advance permission to the next stage. The stage loads when clear is high,
// or when it is allowed to advance and its own terminal-count flag is set.
// Assumes the stage only ever reloads zero data.
module bcdc_stage_ctrl (
    input  logic adv_in,
    input  logic clear,
    input  logic at_top,
    output logic load,
    output logic adv_next
);
    // Combine the clear input with this stage's own terminal-count feedback.
    always_comb begin
        load     = clear | (adv_in & at_top);
        adv_next = adv_in & at_top;
    end
endmodule

// File: rtl/bcdc_load_counter.sv
// Binary counter with a parallel-load path and a terminal-count flag.
// Load takes precedence over advance. Assumes a load always happens at or
// before TOP, so the value never passes TOP.
module bcdc_load_counter #(
    parameter int W   = 4,
    parameter int TOP = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic         at_top
);
    localparam logic [W-1:0] TOP_V = W'(TOP);
    localparam logic [W-1:0] ONE_V = W'(1);

    // State register: reset, then parallel load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (adv)
            q <= q + ONE_V;
    end

    // Terminal-count detection.
    always_comb at_top = (q == TOP_V);

    p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q <= TOP_V);
    p_load_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(load_val));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> q == $past(q) + ONE_V);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(q));
endmodule

// File: rtl/bcd_duo_counter.sv
// Two-digit decimal counter made of cascaded load-capable stages.
// The advance permission ripples up the stages: each stage passes it on
// only while it holds 9. Assumes synchronous, active-low reset.
module bcd_duo_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    output logic [3:0] units_o,
    output logic [3:0] tens_o,
    output logic       carry_out
);
    import bcdc_pkg::*;

    localparam digit_t ZERO_D = '0;
    localparam digit_t TOP_D  = digit_t'(DIGIT_TOP);

    logic   adv_chain [NUM_DIG+1];
    digit_t dig_q     [NUM_DIG];
    logic   dig_top   [NUM_DIG];
    logic   dig_load  [NUM_DIG];

    // The head of the advance chain is the global enable.
    always_comb adv_chain[0] = enable;

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_stage
        bcdc_stage_ctrl u_ctrl (
            .adv_in   (adv_chain[g]),
            .clear    (clear),
            .at_top   (dig_top[g]),
            .load     (dig_load[g]),
            .adv_next (adv_chain[g+1])
        );
        bcdc_load_counter #(.W(DIGIT_W), .TOP(DIGIT_TOP)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv_chain[g]),
            .load     (dig_load[g]),
            .load_val (ZERO_D),
            .q        (dig_q[g]),
            .at_top   (dig_top[g])
        );
    end

    // Map the stages onto the output digits and the decade carry.
    always_comb begin
        units_o   = dig_q[0];
        tens_o    = dig_q[1];
        carry_out = adv_chain[NUM_DIG];
    end

    p_tens_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(enable && units_o == TOP_D)) |=> $stable(tens_o));
    p_units_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && enable && units_o == TOP_D) |=> units_o == ZERO_D);
    p_full_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && enable && units_o == TOP_D && tens_o == TOP_D)
        |=> (units_o == ZERO_D && tens_o == ZERO_D));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (units_o == ZERO_D && tens_o == ZERO_D));
    p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (enable && units_o == TOP_D && tens_o == TOP_D));
endmodule

// File: tb/sim_bcd_duo_counter.sv
module sim_bcd_duo_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] units_o;
    logic [3:0] tens_o;
    logic       carry_out;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 1'b0;

    bcd_duo_counter u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .units_o(units_o), .tens_o(tens_o), .carry_out(carry_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check carry, update model, compare.
    task automatic step(input logic r, input logic c, input logic e);
        string tag;
        int prev;
        @(negedge clk);
        rst_n = r; clear = c; enable = e;
        #1;
        if (r) check("R8 carry", int'(carry_out), (e && model == 99) ? 1 : 0);
        prev = model;
        if (!r) begin model = 0; tag = "R1 reset"; end
        else if (c) begin model = 0; tag = "R6 clear"; end
        else if (!e) tag = "R7 hold";
        else begin
            model = (model + 1) % 100;
            if (prev == 99) tag = "R5 wrap";
            else if (prev % 10 == 9) tag = "R3/R4 rollover";
            else tag = "R2 step";
        end
        @(posedge clk);
        #1;
        check({tag, " units"}, int'(units_o), model % 10);
        check({tag, " tens"}, int'(tens_o), model / 10);
        check("R9 range", int'(units_o <= 4'd9 && tens_o <= 4'd9), 1);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(0, 0, 0);
        step(0, 0, 1);
        // R2 R3 R4 R5: long enabled run through 99 -> 00
        for (int i = 0; i < 150; i++) step(1, 0, 1);
        // R7: gapped enable
        for (int i = 0; i < 60; i++) step(1, 0, (i % 3) != 0);
        // R6: clear with enable high, then with enable low
        step(1, 1, 1);
        for (int i = 0; i < 23; i++) step(1, 0, 1);
        step(1, 1, 0);
        // R1: reset mid count
        for (int i = 0; i < 17; i++) step(1, 0, 1);
        step(0, 0, 1);
        // R8: park at 99 with enable low, then wrap
        for (int i = 0; i < 99; i++) step(1, 0, 1);
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        step(1, 1, 1);
        for (int i = 0; i < 99; i++) step(1, 0, 1);
        step(1, 0, 1);
        step(1, 0, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule